// File: doc/BRIEF.md
# Flag-Driven Target Address Calculator

This block resolves the operand location of one decoded memory-reference instruction. It takes six addressing flags, an address field, the address of the following instruction, and the current base and index register values. From these it forms a 20-bit target address or an immediate operand. All address arithmetic is combinational. The result comes out of registers, one cycle after the request.

The flags select the mode. Base-relative and PC-relative modes add a register to the displacement. Direct mode uses the displacement as it stands. Extended mode uses the full 20-bit field. Immediate mode returns the computed value as data. An older compatibility mode packs three flag bits above the displacement to make a 15-bit address.

In indirect mode the block reads one 24-bit pointer word from memory through a request/acknowledge handshake. The low 20 bits of that word become the final address. Flag combinations that have no meaning are reported on an error output, and they start no memory read.

Top module: `ta_resolver`

## Requirements
- R1: `flags` bit order is {n,i,x,b,p,e}, with n as bit 5. When n=1, i=1, b=0, p=0 and e=0 (direct mode), `done` is high in the cycle after `start`, `kind` is 2'b01 and `result` is the low 12 bits of `field`, zero-extended.
- R2: When n=1, i=1, b=1, p=0 and e=0 (base-relative mode), `result` is the low 20 bits of `base_val` plus the low 12 bits of `field` taken as an unsigned value.
- R3: When b=0, p=1 and e=0, and n and i are not both 0 (PC-relative mode), `result` is the low 20 bits of `next_pc` plus the low 12 bits of `field` taken as a signed value from -2048 to 2047.
- R4: When n=0 and i=1 (immediate mode), `kind` is 2'b00 and `result` is the value computed from the b, p and e rules.
- R5: When e=1 and n and i are not both 0 (extended mode), all 20 bits of `field` are used as the offset, and b and p are not used.
- R6: When n=0 and i=0 (compatibility mode), the offset is the 15-bit value {b,p,e,field[11:0]}, `kind` is 2'b01, and no combination of b and p is treated as illegal.
- R7: When x=1, the low 20 bits of `index_val` are added. Every sum wraps modulo 2^20, and bits 23:20 of `base_val`, `next_pc` and `index_val` have no effect.
- R8: When n=1 and i=0 (indirect mode), `mem_req` rises in the cycle after `start`, with `mem_addr` set to the computed address. Both stay unchanged until `mem_ack` is sampled high. In the cycle after that, `done` is high, `kind` is 2'b10 and `result` is `mem_rdata[19:0]`.
- R9: Two cases are illegal: b=1 with p=1 when n and i are not both 0, and x=1 when n differs from i. For an illegal request, `done` and `err` are high in the cycle after `start`, with `kind`=2'b11 and `result`=0, and no memory read is made.
- R10: While `busy` is high (an indirect read is outstanding), `start` is ignored. The pending read and its result are unaffected.
- R11: During and right after reset, `done`, `err`, `busy` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe; inputs sampled with it |
| flags | input | 6 | Addressing flags {n,i,x,b,p,e} |
| field | input | 20 | Displacement in bits 11:0, or the full address in extended mode |
| next_pc | input | 24 | Address of the following instruction |
| base_val | input | 24 | Base register value |
| index_val | input | 24 | Index register value |
| busy | output | 1 | Indirect read outstanding |
| done | output | 1 | One-cycle completion strobe |
| result | output | 20 | Target address or immediate operand |
| kind | output | 2 | 00 immediate, 01 direct, 10 indirect, 11 error |
| err | output | 1 | Illegal flag combination, strobed with done |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 20 | Pointer read address |
| mem_ack | input | 1 | Pointer read completion |
| mem_rdata | input | 24 | Pointer word |

## Verification
Direct, immediate, compatibility-mode and error results are due one cycle after `start`. An indirect request raises `mem_req` after one cycle. Its `done` arrives one cycle after the cycle in which `mem_ack` is high, so the total is two cycles plus the number of wait states. The bench's reference model advances one step per clock, using the same inputs the design sampled at that edge. Each expectation is compared at the falling edge that follows, so every result is checked exactly in the cycle it is due. The model also checks that `start` pulses issued during a wait leave the pending read untouched.

// File: rtl/ta_pkg.sv
package ta_pkg;
    localparam int ADDR_W = 20;
    localparam int WORD_W = 24;
    localparam int DISP_W = 12;

    typedef enum logic [1:0] {
        OPK_IMM = 2'b00,
        OPK_DIR = 2'b01,
        OPK_IND = 2'b10,
        OPK_BAD = 2'b11
    } opkind_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_BASE = 2'b01,
        SRC_PC   = 2'b10
    } basesrc_e;

    typedef enum logic [1:0] {
        OFF_U12 = 2'b00,
        OFF_S12 = 2'b01,
        OFF_LEG = 2'b10,
        OFF_EXT = 2'b11
    } offfmt_e;

    typedef struct packed {
        logic n;
        logic i;
        logic x;
        logic b;
        logic p;
        logic e;
    } flags_t;

    typedef struct packed {
        opkind_e  kind;
        basesrc_e src;
        offfmt_e  fmt;
        logic     add_x;
        logic     bad;
    } plan_t;

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction
endpackage

// File: rtl/ta_mode_decode.sv
module ta_mode_decode
    import ta_pkg::*;
(
    input  flags_t fl,
    output plan_t  pl
);
    logic compat;

    always_comb begin
        compat   = ~fl.n & ~fl.i;
        pl.bad   = (~compat & fl.b & fl.p) | (fl.x & (fl.n ^ fl.i));
        pl.add_x = fl.x;

        if (pl.bad)             pl.kind = OPK_BAD;
        else if (compat)        pl.kind = OPK_DIR;
        else if (fl.n && fl.i)  pl.kind = OPK_DIR;
        else if (fl.i)          pl.kind = OPK_IMM;
        else                    pl.kind = OPK_IND;

        if (compat) begin
            pl.src = SRC_NONE;
            pl.fmt = OFF_LEG;
        end else if (fl.e) begin
            pl.src = SRC_NONE;
            pl.fmt = OFF_EXT;
        end else if (fl.b) begin
            pl.src = SRC_BASE;
            pl.fmt = OFF_U12;
        end else if (fl.p) begin
            pl.src = SRC_PC;
            pl.fmt = OFF_S12;
        end else begin
            pl.src = SRC_NONE;
            pl.fmt = OFF_U12;
        end
    end
endmodule

// File: rtl/ta_addr_sum.sv
module ta_addr_sum
    import ta_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W,
    parameter int DW = DISP_W
) (
    input  plan_t          pl,
    input  flags_t         fl,
    input  logic [AW-1:0]  fld,
    input  logic [WW-1:0]  pc_val,
    input  logic [WW-1:0]  b_val,
    input  logic [WW-1:0]  x_val,
    output logic [AW-1:0]  ta
);
    localparam int PAD_LEG = AW - DW - 3;

    logic [AW-1:0] base_part, off_part, idx_part;
    logic [DW-1:0] disp;

    always_comb begin
        disp = fld[DW-1:0];
        unique case (pl.src)
            SRC_BASE: base_part = b_val[AW-1:0];
            SRC_PC:   base_part = pc_val[AW-1:0];
            default:  base_part = '0;
        endcase
        unique case (pl.fmt)
            OFF_S12: off_part = sext_disp(disp);
            OFF_LEG: off_part = {{PAD_LEG{1'b0}}, fl.b, fl.p, fl.e, disp};
            OFF_EXT: off_part = fld;
            default: off_part = {{(AW-DW){1'b0}}, disp};
        endcase
        idx_part = pl.add_x ? x_val[AW-1:0] : '0;
        ta = base_part + off_part + idx_part;
    end
endmodule

// File: rtl/ta_indirect_seq.sv
module ta_indirect_seq
    import ta_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  plan_t         pl,
    input  logic [AW-1:0] ta,
    input  logic          mem_ack,
    input  logic [WW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] result,
    output opkind_e       kind,
    output logic          err,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;
    st_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            done     <= 1'b0;
            err      <= 1'b0;
            result   <= '0;
            kind     <= OPK_DIR;
            mem_addr <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (st)
                ST_IDLE: if (start) begin
                    if (pl.bad) begin
                        done   <= 1'b1;
                        err    <= 1'b1;
                        kind   <= OPK_BAD;
                        result <= '0;
                    end else if (pl.kind == OPK_IND) begin
                        st       <= ST_WAIT;
                        mem_addr <= ta;
                    end else begin
                        done   <= 1'b1;
                        kind   <= pl.kind;
                        result <= ta;
                    end
                end
                ST_WAIT: if (mem_ack) begin
                    st     <= ST_IDLE;
                    done   <= 1'b1;
                    kind   <= OPK_IND;
                    result <= mem_rdata[AW-1:0];
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (st == ST_WAIT);
    assign mem_req = busy;

    // R8
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
    // R8
    no_done_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !done);
    // R8
    ind_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        done && kind == OPK_IND |-> $past(mem_req && mem_ack));
    // R9
    err_from_req_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(start && !busy) && !mem_req);
    // R10
    req_from_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(start));
endmodule

// File: rtl/ta_resolver.sv
module ta_resolver
    import ta_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int WW = WORD_W,
    parameter int DW = DISP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [5:0]    flags,
    input  logic [AW-1:0] field,
    input  logic [WW-1:0] next_pc,
    input  logic [WW-1:0] base_val,
    input  logic [WW-1:0] index_val,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] result,
    output logic [1:0]    kind,
    output logic          err,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ack,
    input  logic [WW-1:0] mem_rdata
);
    flags_t        fl;
    plan_t         pl;
    logic [AW-1:0] ta;
    opkind_e       kind_q;

    assign fl = flags_t'(flags);

    ta_mode_decode u_dec (.fl(fl), .pl(pl));

    ta_addr_sum #(.AW(AW), .WW(WW), .DW(DW)) u_sum (
        .pl(pl), .fl(fl), .fld(field), .pc_val(next_pc),
        .b_val(base_val), .x_val(index_val), .ta(ta)
    );

    ta_indirect_seq #(.AW(AW), .WW(WW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .pl(pl), .ta(ta),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .result(result), .kind(kind_q), .err(err),
        .mem_req(mem_req), .mem_addr(mem_addr)
    );

    assign kind = kind_q;

    // R9
    err_kind_chk: assert property (@(posedge clk) disable iff (rst)
        done && !err |-> kind != 2'b11);
endmodule

// File: tb/ta_resolver_bench.sv
module ta_resolver_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  flags = '0;
    logic [19:0] field = '0;
    logic [23:0] next_pc = '0, base_val = '0, index_val = '0;
    logic        mem_ack = 1'b0;
    logic [23:0] mem_rdata = '0;
    logic        busy, done, err, mem_req;
    logic [19:0] result, mem_addr;
    logic [1:0]  kind;

    int checks = 0, errors = 0;
    string cur = "R11";

    // reference model state
    bit m_busy, m_done, m_err, m_req;
    int m_res, m_kind, m_addr;

    always #4 clk = ~clk;

    ta_resolver u_ta_resolver (
        .clk(clk), .rst(rst), .start(start), .flags(flags), .field(field),
        .next_pc(next_pc), .base_val(base_val), .index_val(index_val),
        .busy(busy), .done(done), .result(result), .kind(kind), .err(err),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    function automatic int ref_ta(logic [5:0] f, logic [19:0] fld,
                                  logic [23:0] pc, logic [23:0] bv, logic [23:0] xv);
        int d, off, base;
        d = int'(fld) & 'hFFF;
        base = 0;
        if (!f[5] && !f[4])  off = (int'(f[2]) * 16384) + (int'(f[1]) * 8192) + (int'(f[0]) * 4096) + d;
        else if (f[0])       off = int'(fld);
        else if (f[2])       begin base = int'(bv) & 'hFFFFF; off = d; end
        else if (f[1])       begin base = int'(pc) & 'hFFFFF; off = (d >= 2048) ? d - 4096 : d; end
        else                 off = d;
        if (f[3]) base = base + (int'(xv) & 'hFFFFF);
        return (base + off) & 'hFFFFF;
    endfunction

    function automatic bit ref_bad(logic [5:0] f);
        bit compat = !f[5] && !f[4];
        return (!compat && f[2] && f[1]) || (f[3] && (f[5] != f[4]));
    endfunction

    task automatic model_tick();
        if (rst) begin
            m_busy = 0; m_done = 0; m_err = 0; m_req = 0;
            return;
        end
        m_done = 0; m_err = 0;
        if (!m_busy) begin
            if (start) begin
                if (ref_bad(flags)) begin
                    m_done = 1; m_err = 1; m_kind = 3; m_res = 0;
                end else if (flags[5] && !flags[4]) begin
                    m_busy = 1; m_req = 1;
                    m_addr = ref_ta(flags, field, next_pc, base_val, index_val);
                end else begin
                    m_done = 1;
                    m_kind = (!flags[5] && flags[4]) ? 0 : 1;
                    m_res = ref_ta(flags, field, next_pc, base_val, index_val);
                end
            end
        end else if (mem_ack) begin
            m_busy = 0; m_req = 0; m_done = 1; m_kind = 2;
            m_res = int'(mem_rdata) & 'hFFFFF;
        end
    endtask

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        model_tick();
        cmp("done", int'(done), int'(m_done));
        cmp("err", int'(err), int'(m_err));
        cmp("busy", int'(busy), int'(m_busy));
        cmp("mem_req", int'(mem_req), int'(m_req));
        if (m_req)  cmp("mem_addr", int'(mem_addr), m_addr);
        if (m_done) begin
            cmp("result", int'(result), m_res);
            cmp("kind", int'(kind), m_kind);
        end
    endtask

    task automatic run_op(string tag, logic [5:0] f, logic [19:0] fld, logic [23:0] pc,
                          logic [23:0] bv, logic [23:0] xv, int waits, logic [23:0] rd);
        cur = tag;
        flags = f; field = fld; next_pc = pc; base_val = bv; index_val = xv;
        start = 1'b1;
        step();
        start = 1'b0;
        if (m_busy) begin
            for (int k = 0; k < waits; k++) step();
            mem_rdata = rd; mem_ack = 1'b1;
            step();
            mem_ack = 1'b0;
        end
        step();
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset state
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        step();

        run_op("R1",  6'b110000, 20'h00123, 24'h0, 24'h0, 24'h0, 0, 24'h0);
        run_op("R7",  6'b111000, 20'h00100, 24'h0, 24'h0, 24'hF00050, 0, 24'h0);
        run_op("R2",  6'b110100, 20'h00FFF, 24'h0, 24'hA01000, 24'h0, 0, 24'h0);
        run_op("R3",  6'b110010, 20'h007FF, 24'h000003, 24'h0, 24'h0, 0, 24'h0);
        run_op("R3",  6'b110010, 20'h00FFA, 24'h000006, 24'h0, 24'h0, 0, 24'h0);
        run_op("R3",  6'b110010, 20'h00800, 24'h000002, 24'h0, 24'h0, 0, 24'h0);
        run_op("R4",  6'b010010, 20'h00008, 24'h000003, 24'h0, 24'h0, 0, 24'h0);
        run_op("R4",  6'b010100, 20'h00010, 24'h0, 24'h000200, 24'h0, 0, 24'h0);
        run_op("R5",  6'b110001, 20'hABCDE, 24'h0, 24'h0, 24'h0, 0, 24'h0);
        run_op("R5",  6'b110101, 20'h12345, 24'h0, 24'h000777, 24'h0, 0, 24'h0);
        run_op("R7",  6'b111001, 20'hFFFFF, 24'h0, 24'h0, 24'hFF0002, 0, 24'h0);
        run_op("R6",  6'b000111, 20'h00234, 24'h0, 24'h0, 24'h0, 0, 24'h0);
        run_op("R6",  6'b001101, 20'h00FFF, 24'h0, 24'h0, 24'h000010, 0, 24'h0);
        run_op("R8",  6'b100000, 20'h00040, 24'h0, 24'h0, 24'h0, 0, 24'hAB1234);
        run_op("R8",  6'b100010, 20'h00010, 24'h000100, 24'h0, 24'h0, 3, 24'h0C0FFE);
        run_op("R9",  6'b110110, 20'h00001, 24'h0, 24'h0, 24'h0, 0, 24'h0);
        run_op("R9",  6'b011000, 20'h00001, 24'h0, 24'h0, 24'h0, 0, 24'h0);
        run_op("R9",  6'b101000, 20'h00001, 24'h0, 24'h0, 24'h0, 0, 24'h0);

        // R10: start pulses during an outstanding read are ignored
        cur = "R10";
        flags = 6'b100000; field = 20'h00300; start = 1'b1;
        step();
        flags = 6'b110000; field = 20'h00555;
        step(); step();
        start = 1'b0;
        mem_rdata = 24'h054321; mem_ack = 1'b1;
        step();
        mem_ack = 1'b0;
        step();

        // R1: back-to-back direct requests
        cur = "R1";
        start = 1'b1;
        flags = 6'b110000; field = 20'h00AAA; step();
        field = 20'h00BBB; step();
        start = 1'b0; step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule